// File: doc/BRIEF.md
# Interrupt Status and Mask Register Set

This block keeps the interrupt state of a peripheral with fourteen event sources. Single-cycle event pulses from the datapath latch into a sticky status register, and software clears status bits by writing ones to them. The mask register cannot be written directly. Software writes ones to an enable register to set mask bits and ones to a disable register to clear them, so one source can be changed without a read-modify-write of the others.

A single registered interrupt line is high while any status bit is set and also enabled in the mask. Register access is a plain single-cycle port. Writes take effect on the clock edge. Reads are combinational from the current register contents.

Bit i of the event vector, the mask and the status belongs to source i. The source order is: RX trigger, RX empty, RX full, TX empty, TX full, RX overrun, framing error, parity error, RX timeout, modem status change, TX trigger, TX nearly full, TX overflow, RX break.

Top module: `intr_regs_top`

## Requirements
- R1: After reset the mask and status registers read zero and `irqOut` is low.
- R2: A 1 on bit i of `eventIn` at a clock edge sets status bit i, and the bit stays set after the pulse ends. Status reads at offset 0x14.
- R3: A write to offset 0x14 clears each status bit whose write-data bit is 1. Bits written 0 are unchanged.
- R4: If an event and a write-1-to-clear hit the same status bit in the same cycle, the bit stays set.
- R5: A write to offset 0x08 sets each mask bit whose write-data bit is 1. Mask bits written 0 are unchanged.
- R6: A write to offset 0x0C clears each mask bit whose write-data bit is 1. Mask bits written 0 are unchanged.
- R7: The mask reads at offset 0x10. A write to 0x10 does not change the mask or the status.
- R8: `irqOut` is high exactly when, at the previous clock edge, the bitwise AND of mask and status was non-zero. It therefore drops one cycle after the last enabled pending bit is cleared or disabled.
- R9: Read data bits 31 to 14 are always zero. Reads of the enable offset, the disable offset and any unmapped offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | 8 | Byte offset of the register being read or written |
| regWrData | input | 14 | Write data, one bit per source |
| regRdData | output | 32 | Read data for `regAddr` |
| eventIn | input | 14 | Raw event pulses, one bit per source |
| irqOut | output | 1 | Registered interrupt request |

## Verification
The mask is built up by enable writes that mix ones and zeros, and is then partly cleared by disable writes, so that set-only and clear-only behaviour each show up against untouched bits. Events are pulsed on masked and unmasked sources, which separates latching from interrupt generation. Status clears are tried with all-zero data, single-bit data and data that collides with an event in the same cycle. A long stretch of random writes to every offset, combined with random event vectors, is compared each clock against a behavioural model. This exposes wrong decode, wrong priority and wrong timing of the interrupt edge.

// File: rtl/intr_regs_pkg.sv
package intr_regs_pkg;
  parameter int NUM_SRC = 14;
  parameter int ADDR_W  = 8;
  parameter int DATA_W  = 32;

  localparam logic [ADDR_W-1:0] OFS_ENABLE  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFS_DISABLE = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFS_MASK    = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFS_STATUS  = ADDR_W'(8'h14);

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_MASK = 2'd1,
    RD_STAT = 2'd2
  } rdSel_e;

  typedef struct packed {
    logic [NUM_SRC-1:0] maskSet;
    logic [NUM_SRC-1:0] maskClr;
    logic [NUM_SRC-1:0] statClr;
    rdSel_e             rdSel;
  } strobes_t;
endpackage

// File: rtl/intr_regs_ctrl.sv
module intr_regs_ctrl
  import intr_regs_pkg::*;
(
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [NUM_SRC-1:0] regWrData,
  output strobes_t           strb
);
  logic hitEnable, hitDisable, hitStatus, hitMask;

  always_comb begin
    hitEnable  = (regAddr == OFS_ENABLE);
    hitDisable = (regAddr == OFS_DISABLE);
    hitStatus  = (regAddr == OFS_STATUS);
    hitMask    = (regAddr == OFS_MASK);

    strb.maskSet = (regWrEn && hitEnable)  ? regWrData : '0;
    strb.maskClr = (regWrEn && hitDisable) ? regWrData : '0;
    strb.statClr = (regWrEn && hitStatus)  ? regWrData : '0;

    if (hitMask)        strb.rdSel = RD_MASK;
    else if (hitStatus) strb.rdSel = RD_STAT;
    else                strb.rdSel = RD_NONE;
  end
endmodule

// File: rtl/intr_regs_dp.sv
module intr_regs_dp
  import intr_regs_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           strb,
  input  logic [NUM_SRC-1:0] eventIn,
  output logic [NUM_SRC-1:0] maskQ,
  output logic [NUM_SRC-1:0] statusQ,
  output logic               irqOut,
  output logic [DATA_W-1:0]  regRdData
);
  localparam int PAD_W = DATA_W - NUM_SRC;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    // mask bit: set and clear strobes come from different offsets
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 maskQ[i] <= 1'b0;
      else if (strb.maskSet[i])  maskQ[i] <= 1'b1;
      else if (strb.maskClr[i])  maskQ[i] <= 1'b0;
    end
    // status bit: a new event beats a simultaneous clear
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 statusQ[i] <= 1'b0;
      else if (eventIn[i])       statusQ[i] <= 1'b1;
      else if (strb.statClr[i])  statusQ[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |(maskQ & statusQ);
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_MASK: regRdData = {{PAD_W{1'b0}}, maskQ};
      RD_STAT: regRdData = {{PAD_W{1'b0}}, statusQ};
      default: regRdData = '0;
    endcase
  end
endmodule

// File: rtl/intr_regs_top.sv
module intr_regs_top
  import intr_regs_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [NUM_SRC-1:0] regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [NUM_SRC-1:0] eventIn,
  output logic               irqOut
);
  strobes_t           strb;
  logic [NUM_SRC-1:0] maskQ;
  logic [NUM_SRC-1:0] statusQ;

  intr_regs_ctrl u_ctrl (
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .strb      (strb)
  );

  intr_regs_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .eventIn   (eventIn),
    .maskQ     (maskQ),
    .statusQ   (statusQ),
    .irqOut    (irqOut),
    .regRdData (regRdData)
  );
endmodule

// File: rtl/intr_regs_chk.sv
module intr_regs_chk
  import intr_regs_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [DATA_W-1:0]  regRdData,
  input logic [NUM_SRC-1:0] eventIn,
  input logic [NUM_SRC-1:0] maskQ,
  input logic [NUM_SRC-1:0] statusQ,
  input logic               irqOut
);
  p_event_latch_r2: assert property (@(posedge clk) disable iff (!rstN)
    (eventIn != '0) |=> ((statusQ & $past(eventIn)) == $past(eventIn)));

  p_no_stray_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == OFS_STATUS) |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && (regAddr == OFS_ENABLE || regAddr == OFS_DISABLE)) |=> $stable(maskQ));

  p_irq_timing_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (|($past(maskQ & statusQ))));

  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[DATA_W-1:NUM_SRC] == '0);
endmodule

bind intr_regs_top intr_regs_chk u_chk (.*);

// File: tb/intr_regs_top_test.sv
`timescale 1ns/1ps
module intr_regs_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [13:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [13:0] eventIn = '0;
  logic        irqOut;

  int checks = 0;
  int fails = 0;
  string curReq = "R1";
  bit done = 1'b0;

  // behavioural model state
  int mMask = 0;
  int mStat = 0;
  bit mIrq = 0;

  always #2.5 clk = ~clk;

  intr_regs_top uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .eventIn(eventIn), .irqOut(irqOut)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMask = 0; mStat = 0; mIrq = 0;
    end else begin
      mIrq = ((mMask & mStat) != 0);
      if (regWrEn) begin
        if (regAddr == 8'h08) mMask = mMask | int'(regWrData);
        if (regAddr == 8'h0C) mMask = mMask & ~int'(regWrData);
        if (regAddr == 8'h14) mStat = mStat & ~int'(regWrData);
      end
      mStat = mStat | int'(eventIn);
    end
  end

  function automatic logic [31:0] expRead(logic [7:0] a);
    if (a == 8'h10) return 32'(mMask);
    if (a == 8'h14) return 32'(mStat);
    return 32'h0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // wait to mid-cycle, compare, then drive the next cycle's inputs
  task automatic cyc(bit we, logic [7:0] a, logic [13:0] d, logic [13:0] ev);
    @(negedge clk);
    chk({curReq, " read"}, regRdData, expRead(regAddr));
    chk({curReq, " irq"}, {31'b0, irqOut}, {31'b0, mIrq});
    regWrEn = we; regAddr = a; regWrData = d; eventIn = ev;
  endtask

  task automatic rd(logic [7:0] a);
    cyc(1'b0, a, '0, '0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset contents
    curReq = "R1";
    regAddr = 8'h10;
    @(negedge clk);
    chk("R1 mask", regRdData, 32'h0);
    chk("R1 irq", {31'b0, irqOut}, 32'h0);
    regAddr = 8'h14;
    @(negedge clk);
    chk("R1 status", regRdData, 32'h0);
    rstN = 1'b1;
    rd(8'h14);

    curReq = "R5";
    cyc(1'b1, 8'h08, 14'h0005, '0);
    cyc(1'b1, 8'h08, 14'h0002, '0);
    rd(8'h10);
    rd(8'h10);

    curReq = "R6";
    cyc(1'b1, 8'h0C, 14'h0001, '0);
    rd(8'h10);
    rd(8'h10);

    curReq = "R7";
    cyc(1'b1, 8'h10, 14'h3FFF, '0);
    rd(8'h10);
    rd(8'h14);

    curReq = "R2";
    cyc(1'b0, 8'h14, '0, 14'h0100);
    rd(8'h14);
    rd(8'h14);
    cyc(1'b0, 8'h14, '0, 14'h0004);
    rd(8'h14);

    curReq = "R8";
    rd(8'h14);
    cyc(1'b1, 8'h14, 14'h0004, '0);
    rd(8'h14);
    rd(8'h14);

    curReq = "R3";
    cyc(1'b1, 8'h14, 14'h0000, '0);
    rd(8'h14);
    cyc(1'b1, 8'h14, 14'h0100, '0);
    rd(8'h14);

    curReq = "R4";
    cyc(1'b0, 8'h14, '0, 14'h0002);
    rd(8'h14);
    cyc(1'b1, 8'h14, 14'h0002, 14'h0002);
    rd(8'h14);
    rd(8'h14);

    curReq = "R8";
    cyc(1'b1, 8'h0C, 14'h0002, '0);
    rd(8'h14);
    rd(8'h14);

    curReq = "R9";
    cyc(1'b1, 8'h08, 14'h3FFF, 14'h3FFF);
    rd(8'h08);
    rd(8'h0C);
    rd(8'h00);
    rd(8'hFC);
    rd(8'h10);

    curReq = "R2 R3 R4 R5 R6 R7 R8 R9 random";
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      case ($urandom_range(0, 5))
        0: a = 8'h08;
        1: a = 8'h0C;
        2: a = 8'h10;
        3: a = 8'h14;
        4: a = 8'h14;
        default: a = 8'h20;
      endcase
      cyc(1'($urandom_range(0, 1)), a, 14'($urandom),
          ($urandom_range(0, 3) == 0) ? 14'($urandom) : 14'h0);
    end
    rd(8'h14);
    rd(8'h10);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule